// File: doc/BRIEF.md
# Instruction Line Prefetch Buffer

This block sits between a first-level instruction cache and the next memory level. Toward the cache it behaves like an ordinary memory arbiter: the cache raises a request with an address and waits while the block holds its wait line high. The block keeps one aligned 4-word line together with its tag. An instruction fetch whose 2-word block lies in that line is answered in the same cycle. Any other fetch makes the block pull the whole aligned 4-word line from below and then hand up the half that was asked for.

Three states drive the control. IDLE serves hits. REQUEST holds a line request toward the lower level until that level raises its wait. WAIT holds on until the wait drops, which marks the line data on the lower bus as valid. The line is captured on that edge and the block goes back to IDLE, where the fetch that is still pending now hits. A flush input invalidates the stored line.

Top module: `ifetch_line_buf`

## Requirements
- R1: Reset is asynchronous, active low and released synchronously. After reset the block is idle: dn_req is 0, up_wait is 0 while up_req is 0, and the stored line is invalid, so the first request misses.
- R2: A request in IDLE whose address bits [31:4] equal the stored tag of a valid line hits. up_wait is 0 in that same cycle and no lower request is started.
- R3: On a hit, address bit 3 selects the half. With bit 3 at 0, up_rdata carries line bits [63:0], which are words 0 and 1, word 0 in the low bits. With bit 3 at 1, it carries line bits [127:64], which are words 2 and 3. Address bits [2:0] are ignored.
- R4: A request in IDLE that misses raises up_wait in the same cycle. From the next cycle, dn_req is 1 and dn_addr equals the request address with bits [3:0] cleared.
- R5: dn_req stays 1 while the block waits for the lower level to raise dn_wait, and it stays 1 while dn_wait is high.
- R6: In the first cycle in which dn_wait is low after having been high, the block captures dn_rdata as the line. In the next cycle dn_req is 0 and the pending request hits on the new line.
- R7: up_wait is 1 in every cycle in which dn_req is 1, whatever the state of up_req.
- R8: Asserting flush invalidates the line, so the next request to that line misses. A flush in the same cycle as a line capture leaves the line invalid.
- R9: Two addresses that differ in bit 4 or above belong to different lines, so alternating between them misses every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate the stored line |
| up_req | input | 1 | Fetch request from the instruction cache |
| up_addr | input | 32 | Byte address of the fetch |
| up_wait | output | 1 | Stall toward the cache; low means up_rdata is valid |
| up_rdata | output | 64 | Selected 2-word block |
| dn_req | output | 1 | Line request to the lower level |
| dn_addr | output | 32 | Line-aligned address of the request |
| dn_wait | input | 1 | Busy from the lower level; its fall delivers the line |
| dn_rdata | input | 128 | 4-word line from the lower level |

## Verification
The bench sweeps every byte offset of several lines, with varied lower-level latencies. A wrong half select would return the neighbouring words. Hashing in bits [2:0] would turn hits into misses. The bench also covers a line that is fetched and then needed at once: a design that drops the request or reads dn_rdata at the wrong edge would return stale data. It also checks lines that differ only in bit 4, which catch a short tag compare, and a flush that lands on the same edge as the fill, where a design that lets the fill win keeps a line that should be gone.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ifb_state_e;
endpackage

// File: rtl/ifb_rst_sync.sv
module ifb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/ifb_ctrl.sv
module ifb_ctrl
  import ifb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_req,
  input  logic       hit,
  input  logic       dn_wait,
  output ifb_state_e state,
  output logic       start,
  output logic       fill_done,
  output logic       up_wait,
  output logic       dn_req
);
  ifb_state_e state_d;

  // decode of the current state
  assign start     = (state == ST_IDLE) && up_req && !hit;
  assign fill_done = (state == ST_WAIT) && !dn_wait;
  assign dn_req    = (state != ST_IDLE);
  assign up_wait   = dn_req || start;

  // next state
  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (start)    state_d = ST_REQ;
      ST_REQ:  if (dn_wait)  state_d = ST_WAIT;
      ST_WAIT: if (!dn_wait) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/ifb_store.sv
module ifb_store #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                start,
  input  logic                fill_done,
  input  logic [ADDR_W-1:0]   up_addr,
  input  logic [4*WORD_W-1:0] dn_rdata,
  output logic                hit,
  output logic [2*WORD_W-1:0] up_rdata,
  output logic [ADDR_W-1:0]   dn_addr
);
  localparam int OFF_W = $clog2(4*WORD_W/8);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int HALF  = OFF_W - 1;

  logic [TAG_W-1:0]    pend_tag_q, tag_q;
  logic [4*WORD_W-1:0] line_q;
  logic                valid_q, valid_d;
  logic                sel_hi;

  // the half-select bit is not part of the tag
  assign sel_hi  = up_addr[HALF];
  assign hit     = valid_q && (tag_q == up_addr[ADDR_W-1:OFF_W]);
  assign dn_addr = {pend_tag_q, {OFF_W{1'b0}}};

  // a flush wins over a fill that lands on the same edge
  always_comb begin
    valid_d = valid_q;
    if (fill_done) valid_d = 1'b1;
    if (flush)     valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // data registers: no reset, written only when enabled
  always_ff @(posedge clk) begin
    if (start) pend_tag_q <= up_addr[ADDR_W-1:OFF_W];
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      line_q <= dn_rdata;
      tag_q  <= pend_tag_q;
    end
  end

  // the two word lanes of the returned block
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign up_rdata[g*WORD_W +: WORD_W] =
      sel_hi ? line_q[(g+2)*WORD_W +: WORD_W] : line_q[g*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/ifetch_line_buf.sv
module ifetch_line_buf #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                up_req,
  input  logic [ADDR_W-1:0]   up_addr,
  output logic                up_wait,
  output logic [2*WORD_W-1:0] up_rdata,
  output logic                dn_req,
  output logic [ADDR_W-1:0]   dn_addr,
  input  logic                dn_wait,
  input  logic [4*WORD_W-1:0] dn_rdata
);
  import ifb_pkg::*;

  logic       rst_q;
  logic       hit, start, fill_done;
  ifb_state_e state;

  ifb_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  ifb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .up_req    (up_req),
    .hit       (hit),
    .dn_wait   (dn_wait),
    .state     (state),
    .start     (start),
    .fill_done (fill_done),
    .up_wait   (up_wait),
    .dn_req    (dn_req)
  );

  ifb_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_q),
    .flush     (flush),
    .start     (start),
    .fill_done (fill_done),
    .up_addr   (up_addr),
    .dn_rdata  (dn_rdata),
    .hit       (hit),
    .up_rdata  (up_rdata),
    .dn_addr   (dn_addr)
  );
endmodule

// File: rtl/ifb_checker.sv
module ifb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_q,
  input logic              up_req,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_wait,
  input logic              dn_req,
  input logic [ADDR_W-1:0] dn_addr,
  input logic              dn_wait
);
  // R7: the cache is held off whenever a line fetch is outstanding
  assert_wait_while_fetch_R7: assert property (@(posedge clk) disable iff (!rst_q)
    dn_req |-> up_wait);

  // R4: a miss seen in idle launches a lower request on the next cycle
  assert_miss_launches_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (up_req && up_wait && !dn_req) |=> dn_req);

  // R4: the launched request carries the line of the missing address
  assert_line_addr_R4: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(dn_req) |-> dn_addr[ADDR_W-1:4] == $past(up_addr[ADDR_W-1:4]));

  // R2: a hit in idle starts no fetch
  assert_hit_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (!dn_req && up_req && !up_wait) |=> !dn_req);

  // R5: the request is held while the lower level is busy
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (dn_req && dn_wait) |=> dn_req);

  // R6: the request ends only after the lower level released its wait
  assert_req_ends_R6: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(dn_req) |-> !$past(dn_wait));
endmodule

bind ifetch_line_buf ifb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_q   (rst_q),
  .up_req  (up_req),
  .up_addr (up_addr),
  .up_wait (up_wait),
  .dn_req  (dn_req),
  .dn_addr (dn_addr),
  .dn_wait (dn_wait)
);

// File: tb/tb_ifetch_line_buf.sv
module tb_ifetch_line_buf;
  logic         clk, rst_n, flush, up_req, dn_wait;
  logic [31:0]  up_addr;
  logic         up_wait, dn_req;
  logic [63:0]  up_rdata;
  logic [31:0]  dn_addr;
  logic [127:0] dn_rdata;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // bench model of the stored line
  bit          m_valid;
  logic [27:0] m_tag;

  ifetch_line_buf dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .up_req(up_req),
    .up_addr(up_addr), .up_wait(up_wait), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_addr(dn_addr), .dn_wait(dn_wait), .dn_rdata(dn_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] word_of(input logic [31:0] a, input int k);
    return {a[31:4], 2'b00, k[1:0]} ^ 32'hC3A5_0F00;
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] a);
    return {word_of(a,3), word_of(a,2), word_of(a,1), word_of(a,0)};
  endfunction

  function automatic logic [63:0] half_of(input logic [31:0] a);
    return a[3] ? {word_of(a,3), word_of(a,2)} : {word_of(a,1), word_of(a,0)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input int dreq, input int dwt);
    bit exp_hit;
    exp_hit = m_valid && (m_tag == a[31:4]);
    @(negedge clk); up_req = 1'b1; up_addr = a; #1;
    if (exp_hit) begin
      chk(up_wait == 1'b0, "R2 hit wait", up_wait, 0);
      chk(up_rdata == half_of(a), "R3 half select", up_rdata, half_of(a));
    end else begin
      chk(up_wait == 1'b1, "R4 miss wait", up_wait, 1);
      @(negedge clk); #1;
      chk(dn_req && dn_addr == {a[31:4], 4'h0}, "R4 line request", dn_addr,
          {a[31:4], 4'h0});
      for (int i = 0; i < dreq; i++) begin
        @(negedge clk); #1;
        chk(dn_req && up_wait, "R5 R7 request held", {dn_req, up_wait}, 2'b11);
      end
      dn_wait = 1'b1;
      for (int i = 0; i <= dwt; i++) begin
        @(negedge clk); #1;
        chk(dn_req && up_wait, "R5 R7 held in wait", {dn_req, up_wait}, 2'b11);
      end
      dn_wait = 1'b0; dn_rdata = line_of(a);
      @(negedge clk); dn_rdata = ~line_of(a); #1;
      chk(!dn_req, "R6 request drops", dn_req, 0);
      chk(!up_wait && up_rdata == half_of(a), "R6 fill then hit", up_rdata, half_of(a));
      m_valid = 1'b1; m_tag = a[31:4];
    end
    @(negedge clk); up_req = 1'b0;
  endtask

  function automatic logic [31:0] line_base(input int i);
    return 32'h0000_1000 + i * 32'h0010_0010;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; up_req = 1'b0; dn_wait = 1'b0;
    up_addr = '0; dn_rdata = '0; m_valid = 1'b0; m_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: idle after reset
    chk(!dn_req, "R1 dn_req after reset", dn_req, 0);
    chk(!up_wait, "R1 up_wait after reset", up_wait, 0);
    up_req = 1'b1; up_addr = 32'h0; #1;
    chk(up_wait, "R1 line invalid after reset", up_wait, 1);
    up_req = 1'b0;

    // R2 R3: every byte offset of several lines, varied latency
    for (int i = 0; i < 8; i++)
      for (int o = 0; o < 16; o++)
        access(line_base(i) + o, i % 3, (i + o) % 2);

    // R9: lines differing only in bit 4 evict each other
    for (int k = 0; k < 4; k++) begin
      access(32'h0000_2000 + (k % 2) * 16 + 8, 1, 0);
      chk(m_tag == (32'h0000_2000 + (k % 2) * 16) >> 4, "R9 bit4 line", m_tag,
          (32'h0000_2000 + (k % 2) * 16) >> 4);
    end

    // R8: flush invalidates the line
    access(32'h0000_3004, 0, 0);
    access(32'h0000_3008, 0, 0);
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0; m_valid = 1'b0;
    up_req = 1'b1; up_addr = 32'h0000_3000; #1;
    chk(up_wait, "R8 miss after flush", up_wait, 1);
    up_req = 1'b0;
    access(32'h0000_3000, 0, 1);

    // R8: flush on the fill edge leaves the line invalid
    @(negedge clk); up_req = 1'b1; up_addr = 32'h0000_4000;
    @(negedge clk); dn_wait = 1'b1;
    @(negedge clk); dn_wait = 1'b0; flush = 1'b1; dn_rdata = line_of(32'h0000_4000);
    @(negedge clk); flush = 1'b0; #1;
    chk(!dn_req, "R8 fill completed", dn_req, 0);
    chk(up_wait, "R8 flush beats fill", up_wait, 1);
    up_req = 1'b0; m_valid = 1'b0;
    access(32'h0000_400C, 2, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule